// File: doc/BRIEF.md
# Three-wire serial bus target

This block is the target end of a three-wire serial link made of a bus clock, a data line and an active-low select. While select is low the host clocks in a 9-bit header, most significant bit first, holding a 3-bit device address, a direction flag and a 5-bit register number. A 16-bit value follows on the same data path. On a write the target assembles the value from the input line and hands it to a local register bank. On a read it fetches the value from that bank and shifts it out on its output data line. Up to eight targets share one bus; each answers only to the device address fixed by its `DEV_ADDR` parameter.

All bus pins are asynchronous to the system clock. They pass through two-flop synchronisers, and a rising edge of the bus clock is detected in the system clock domain. The bus clock therefore has to be a good deal slower than the system clock. The register bank sees a plain parallel port: a register number, a one-cycle write strobe with write data, and a one-cycle read strobe whose data is returned combinationally in the same cycle. The output data line has an enable, which stands in for the tri-state driver at the pad.

Top module: `tw_target`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `reg_wr`, `reg_rd` and `dout_oe` are low.
- R2: Bits are taken only on a rising edge of `bus_clk` while `bus_sel_n` is low; clock edges while select is high leave no trace on the next transfer.
- R3: The header arrives most significant bit first. Header bits 8..6 are the device address, bit 5 is the direction (1 = read, 0 = write) and bits 4..0 are the register number, which appears on `reg_addr`.
- R4: A transfer whose device address differs from `DEV_ADDR` produces no `reg_wr` pulse, no `reg_rd` pulse, and leaves `dout_oe` low throughout.
- R5: A matching write collects 16 value bits, most significant first. After the 16th value bit it raises `reg_wr` for exactly one system cycle, with `reg_wdata` holding the value and `reg_addr` holding the register number.
- R6: A matching read raises `reg_rd` for exactly one system cycle, right after the header, and captures `reg_rdata` in that cycle. There is one pulse per read.
- R7: On a matching read, `dout` presents value bit 15 before the first value clock and moves to the next lower bit on each value-phase rising edge of `bus_clk`.
- R8: `dout_oe` is high only during the value phase of a matching read, and it goes low after the 16th value bit or when select is deasserted.
- R9: Raising `bus_sel_n` aborts a partial transfer. No strobe comes from the aborted part, and the next transfer starts again at the header.
- R10: Bus clock edges after the 16th value bit and before select is deasserted are ignored: there is no second strobe and the written value does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock, asynchronous |
| bus_sel_n | input | 1 | Active-low transfer select, asynchronous |
| bus_din | input | 1 | Serial data in from the host |
| dout | output | 1 | Serial data out toward the host |
| dout_oe | output | 1 | Drive enable for `dout` (low means released) |
| reg_addr | output | 5 | Register number from the last header |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 16 | Write value for the register bank |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 16 | Read value from the register bank, valid while `reg_rd` is high |

## Verification
The assertions assume that the bus pins change slowly enough for every level to be seen by the synchronisers for several system cycles. They also assume that select has been high for at least three system cycles whenever the check on the released output applies. The bench keeps to this by holding each bus clock half-period for eight system cycles, keeping select high through reset, and waiting several half-periods between transfers. Inputs change only on the falling edge of the system clock.

// File: rtl/tw_target_pkg.sv
// Shared widths, header field positions and phase encoding for the
// three-wire serial target. Assumes one header word followed by one value.
package tw_target_pkg;
    parameter int DEV_W  = 3;                    // device address field
    parameter int REG_W  = 5;                    // register number field
    parameter int DATA_W = 16;                   // value word
    parameter int HDR_W  = DEV_W + 1 + REG_W;    // full header length
    parameter int DIR_POS = REG_W;               // direction bit position
    parameter int DEV_LSB = REG_W + 1;           // device field low bit

    typedef enum logic [1:0] {
        PH_HDR    = 2'd0,   // collecting header bits
        PH_RDLOAD = 2'd1,   // one cycle: fetch read value from the bank
        PH_VALUE  = 2'd2,   // collecting or emitting value bits
        PH_DONE   = 2'd3    // value complete, waiting for select high
    } tw_phase_e;
endpackage

// File: rtl/tw_sync.sv
// Two-flop synchroniser bank for asynchronous bus pins.
// Assumes each input level lasts several system clock cycles.
module tw_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic meta_q;
            logic stab_q;
            // Two-stage capture of one asynchronous pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[gi];
                    stab_q <= RST_VAL[gi];
                end else begin
                    meta_q <= d_async[gi];
                    stab_q <= meta_q;
                end
            end
            assign q_sync[gi] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/tw_framer.sv
// Bit framing and header decode. Counts header and value bits on
// rising bus clock edges while select is low, matches the device
// address, and raises the register strobes. Assumes synchronised inputs.
module tw_framer
    import tw_target_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sel_n_s,
    input  logic              din_s,
    output logic [REG_W-1:0]  reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    output logic              tx_load,
    output logic              tx_shift,
    output logic              tx_drive
);
    localparam int MAXB  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W = $clog2(MAXB);
    localparam logic [CNT_W-1:0] HDR_TOP  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_TOP = CNT_W'(DATA_W - 1);

    tw_phase_e         phase_q;
    logic [CNT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic [REG_W-1:0]  reg_q;
    logic              hit_q;
    logic              rd_q;
    logic              wr_q;
    logic              sclk_q;
    logic              rise;
    logic [HDR_W-1:0]  hdr_word;

    // Rising edge of the synchronised bus clock.
    assign rise     = sclk_s & ~sclk_q;
    assign hdr_word = {shreg_q[HDR_W-2:0], din_s};

    // Previous bus clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Phase sequencing, bit counting and header capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HDR;
            bit_q   <= HDR_TOP;
            shreg_q <= '0;
            reg_q   <= '0;
            hit_q   <= 1'b0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            if (sel_n_s) begin
                phase_q <= PH_HDR;
                bit_q   <= HDR_TOP;
                shreg_q <= '0;
                hit_q   <= 1'b0;
                rd_q    <= 1'b0;
            end else begin
                unique case (phase_q)
                    PH_HDR: begin
                        if (rise) begin
                            shreg_q <= {shreg_q[DATA_W-2:0], din_s};
                            if (bit_q == '0) begin
                                hit_q <= (hdr_word[HDR_W-1:DEV_LSB] == DEV_ADDR);
                                rd_q  <= hdr_word[DIR_POS];
                                reg_q <= hdr_word[REG_W-1:0];
                                bit_q <= DATA_TOP;
                                if ((hdr_word[HDR_W-1:DEV_LSB] == DEV_ADDR) &&
                                    hdr_word[DIR_POS])
                                    phase_q <= PH_RDLOAD;
                                else
                                    phase_q <= PH_VALUE;
                            end else begin
                                bit_q <= bit_q - 1'b1;
                            end
                        end
                    end
                    PH_RDLOAD: phase_q <= PH_VALUE;
                    PH_VALUE: begin
                        if (rise) begin
                            shreg_q <= {shreg_q[DATA_W-2:0], din_s};
                            if (bit_q == '0) begin
                                wr_q    <= hit_q & ~rd_q;
                                phase_q <= PH_DONE;
                            end else begin
                                bit_q <= bit_q - 1'b1;
                            end
                        end
                    end
                    default: phase_q <= PH_DONE;
                endcase
            end
        end
    end

    assign reg_addr  = reg_q;
    assign reg_wr    = wr_q;
    assign reg_wdata = shreg_q;
    assign reg_rd    = (phase_q == PH_RDLOAD) & ~sel_n_s;
    assign tx_load   = reg_rd;
    assign tx_shift  = (phase_q == PH_VALUE) & rise & ~sel_n_s;
    assign tx_drive  = (phase_q == PH_VALUE) & hit_q & rd_q & ~sel_n_s;
endmodule

// File: rtl/tw_txshift.sv
// Read-value output shifter: loads the bank value, presents the top bit
// and moves down one bit per advance. Output is released when not driving.
module tw_txshift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              advance,
    input  logic              drive,
    output logic              dout,
    output logic              dout_oe
);
    logic [DATA_W-1:0] tx_q;

    // Load on fetch, shift toward the top bit on each value edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_q <= '0;
        else if (load)    tx_q <= load_val;
        else if (advance) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end

    assign dout    = drive & tx_q[DATA_W-1];
    assign dout_oe = drive;
endmodule

// File: rtl/tw_target.sv
// Top of the three-wire serial bus target: synchronises the bus pins,
// frames and decodes transfers, and drives read data back. Assumes the
// bus clock is well below the system clock rate.
module tw_target
    import tw_target_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic              bus_sel_n,
    input  logic              bus_din,
    output logic              dout,
    output logic              dout_oe,
    output logic [REG_W-1:0]  reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [2:0] pins_s;
    logic       ld;
    logic       adv;
    logic       drv;

    tw_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bus_clk, bus_sel_n, bus_din}),
        .q_sync  (pins_s)
    );

    tw_framer #(.DEV_ADDR(DEV_ADDR)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[2]),
        .sel_n_s   (pins_s[1]),
        .din_s     (pins_s[0]),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .tx_load   (ld),
        .tx_shift  (adv),
        .tx_drive  (drv)
    );

    tw_txshift #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (reg_rdata),
        .advance  (adv),
        .drive    (drv),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );
endmodule

// File: rtl/tw_target_chk.sv
// Property checker for the serial target, attached by bind.
module tw_target_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_sel_n,
    input logic reg_wr,
    input logic reg_rd,
    input logic dout_oe
);
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R5
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd)); // R5
    AST_OE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(reg_rd)); // R8
    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !dout_oe); // R8
    AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_n && $past(bus_sel_n) && $past(bus_sel_n, 2) && $past(bus_sel_n, 3))
        |-> (!dout_oe && !reg_rd)); // R9
endmodule

bind tw_target tw_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel_n (bus_sel_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .dout_oe   (dout_oe)
);

// File: tb/tw_target_bench.sv
module tw_target_bench;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_clk = 1'b0;
    logic        bus_sel_n = 1'b1;
    logic        bus_din = 1'b0;
    logic        dout, dout_oe, reg_wr, reg_rd;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [4:0]  wr_addr_seen = '0;
    logic [15:0] wr_data_seen = '0;
    logic        oe_any = 1'b0;
    logic        oe_clr = 1'b0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    tw_target u_tw_target (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_sel_n(bus_sel_n),
        .bus_din(bus_din), .dout(dout), .dout_oe(dout_oe), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] bank_val(input logic [4:0] r);
        return {r, ~r, r, 1'b1};
    endfunction

    assign reg_rdata = bank_val(reg_addr);

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt       <= wr_cnt + 1;
            wr_addr_seen <= reg_addr;
            wr_data_seen <= reg_wdata;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    always @(negedge clk) begin
        if (oe_clr)       oe_any <= 1'b0;
        else if (dout_oe) oe_any <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic sampled);
        bus_din = b;
        bus_clk = 1'b0;
        wait_cyc(HALF);
        sampled = dout;
        bus_clk = 1'b1;
        wait_cyc(HALF);
    endtask

    // One transfer: header, nval value bits, then extra clocks, then select high.
    task automatic xfer(input logic [2:0] a, input logic rw, input logic [4:0] r,
                        input logic [15:0] d, input int nval, input int extra,
                        output logic [15:0] got);
        logic [8:0] hdr;
        logic s;
        hdr = {a, rw, r};
        got = '0;
        oe_clr = 1'b1;
        wait_cyc(1);
        oe_clr = 1'b0;
        bus_sel_n = 1'b0;
        wait_cyc(HALF);
        for (int i = 8; i >= 0; i--) clock_bit(hdr[i], s);
        for (int i = 15; i >= 16 - nval; i--) begin
            clock_bit(rw ? 1'b0 : d[i], s);
            got[i] = s;
        end
        for (int i = 0; i < extra; i++) clock_bit(1'b1, s);
        bus_clk = 1'b0;
        wait_cyc(HALF);
        bus_sel_n = 1'b1;
        wait_cyc(4 * HALF);
    endtask

    // {dev addr[24:22], dir[21], reg[20:16], data[15:0]}; DEV_ADDR is 5
    localparam logic [24:0] VEC [8] = '{
        {3'd5, 1'b0, 5'h03, 16'hBEEF},
        {3'd5, 1'b1, 5'h03, 16'h0000},
        {3'd5, 1'b0, 5'h1F, 16'h8001},
        {3'd2, 1'b0, 5'h07, 16'h1234},
        {3'd5, 1'b1, 5'h00, 16'h0000},
        {3'd4, 1'b1, 5'h11, 16'h0000},
        {3'd5, 1'b0, 5'h00, 16'hFFFF},
        {3'd5, 1'b1, 5'h1F, 16'h0000}
    };

    initial begin
        logic [15:0] got;
        int w0, r0;
        wait_cyc(5);
        // R1: reset state
        chk(!reg_wr && !reg_rd && !dout_oe, "R1 reset strobes/oe",
            {reg_wr, reg_rd, dout_oe}, 0);
        rst_n = 1'b1;
        wait_cyc(4);
        chk(!reg_wr && !reg_rd && !dout_oe, "R1 after reset release",
            {reg_wr, reg_rd, dout_oe}, 0);

        // Table walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            logic [2:0] a;  logic rw;  logic [4:0] r;  logic [15:0] d;
            bit match;
            {a, rw, r, d} = VEC[v];
            match = (a == 3'd5);
            w0 = wr_cnt; r0 = rd_cnt;
            xfer(a, rw, r, d, 16, 0, got);
            if (!match) begin
                chk(wr_cnt == w0 && rd_cnt == r0, "R4 no strobe for other address",
                    (wr_cnt - w0) + (rd_cnt - r0), 0);
                chk(!oe_any, "R4 output released for other address", oe_any, 0);
            end else if (!rw) begin
                chk(wr_cnt == w0 + 1, "R5 one write strobe", wr_cnt - w0, 1);
                chk(wr_data_seen == d, "R5 write value", wr_data_seen, d);
                chk(wr_addr_seen == r, "R3 write register number", wr_addr_seen, r);
                chk(rd_cnt == r0 && !oe_any, "R8 no drive on write",
                    {rd_cnt - r0, 31'(oe_any)}, 0);
            end else begin
                chk(rd_cnt == r0 + 1, "R6 one read strobe", rd_cnt - r0, 1);
                chk(got == bank_val(r), "R7 read value shifted out", got, bank_val(r));
                chk(oe_any, "R8 drive during read value", oe_any, 1);
                chk(wr_cnt == w0, "R6 no write on read", wr_cnt - w0, 0);
            end
            chk(!dout_oe, "R8 released after transfer", dout_oe, 0);
        end

        // R2: clock toggles with select high are ignored
        bus_din = 1'b1;
        for (int i = 0; i < 9; i++) begin
            bus_clk = 1'b1; wait_cyc(HALF);
            bus_clk = 1'b0; wait_cyc(HALF);
        end
        w0 = wr_cnt;
        xfer(3'd5, 1'b0, 5'h0A, 16'h5A5A, 16, 0, got);
        chk(wr_cnt == w0 + 1 && wr_data_seen == 16'h5A5A && wr_addr_seen == 5'h0A,
            "R2 clocks without select ignored", wr_data_seen, 16'h5A5A);

        // R9: abort inside the header, then a clean write
        w0 = wr_cnt; r0 = rd_cnt;
        bus_sel_n = 1'b0; wait_cyc(HALF);
        for (int i = 0; i < 5; i++) clock_bit(1'b1, got[0]);
        bus_clk = 1'b0; wait_cyc(HALF);
        bus_sel_n = 1'b1; wait_cyc(4 * HALF);
        chk(wr_cnt == w0 && rd_cnt == r0, "R9 header abort no strobe",
            (wr_cnt - w0) + (rd_cnt - r0), 0);
        xfer(3'd5, 1'b0, 5'h15, 16'hC3A5, 16, 0, got);
        chk(wr_cnt == w0 + 1 && wr_data_seen == 16'hC3A5 && wr_addr_seen == 5'h15,
            "R9 restart at header", wr_data_seen, 16'hC3A5);

        // R9: abort inside a write value
        w0 = wr_cnt;
        xfer(3'd5, 1'b0, 5'h02, 16'h0F0F, 10, 0, got);
        chk(wr_cnt == w0, "R9 value abort no write", wr_cnt - w0, 0);

        // R9/R8: abort inside a read value releases the output
        r0 = rd_cnt;
        xfer(3'd5, 1'b1, 5'h06, 16'h0, 7, 0, got);
        chk(rd_cnt == r0 + 1 && got[15:9] == bank_val(5'h06) >> 9,
            "R7 partial read bits", got[15:9], bank_val(5'h06) >> 9);
        chk(!dout_oe, "R9 output released after abort", dout_oe, 0);

        // R10: extra clocks after the value
        w0 = wr_cnt;
        xfer(3'd5, 1'b0, 5'h09, 16'h6C39, 16, 12, got);
        chk(wr_cnt == w0 + 1, "R10 single strobe with extra clocks", wr_cnt - w0, 1);
        chk(wr_data_seen == 16'h6C39, "R10 value kept", wr_data_seen, 16'h6C39);
        r0 = rd_cnt;
        xfer(3'd5, 1'b1, 5'h0C, 16'h0, 16, 8, got);
        chk(rd_cnt == r0 + 1 && got == bank_val(5'h0C), "R10 read with extra clocks",
            got, bank_val(5'h0C));

        // R1: reset in mid transfer clears state
        bus_sel_n = 1'b0; wait_cyc(HALF);
        rst_n = 1'b0; wait_cyc(3);
        chk(!reg_wr && !reg_rd && !dout_oe, "R1 reset mid transfer",
            {reg_wr, reg_rd, dout_oe}, 0);
        bus_sel_n = 1'b1; wait_cyc(4);
        rst_n = 1'b1; wait_cyc(4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule